// File: doc/BRIEF.md
# Five-Stage Add/Store Pipeline with Selectable Destination Routing

This block is a small in-order integer pipeline with five stages: fetch, decode, execute, memory access and write-back. It runs two operations: a register-register add and a store of one word. It holds a 32-entry register file, a word-indexed data memory and an instruction memory. The instruction memory and the register file are filled through loading ports while reset is held. Two observation ports read back any register and any data word.

A build-time parameter, `DEFECT`, picks one of two ways to route the destination register number. When it is 0, the destination number travels with its instruction through every stage register and reaches write-back together with the result. When it is 1, the write-back port takes the destination number live from the decode-stage select mux. The result and the write enable still come from the write-back stage, so a result is written into the register named by whatever word sits in decode at that moment. That word is the instruction three slots younger. No forwarding, stalls, branches or loads exist, so software (here the bench) spaces dependent instructions itself.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous active-high reset empties every stage register, sets the fetch index to 0 and clears all data memory words to zero. Register file contents are not changed by reset.
- R2: With `DEFECT`=0, an add (bits 31:26 = 0, bits 5:0 = 0x20, bits 10:6 = 0) writes the sum of the registers named by bits 25:21 and bits 20:16 into the register named by bits 15:11. The write happens in the write-back cycle, four cycles after the add was fetched.
- R3: A store (bits 31:26 = 0x2B) writes the register named by bits 20:16 into the data word addressed by the register in bits 25:21 plus the sign-extended offset in bits 15:0. The word index is the low log2(DMEM_DEPTH) bits of that sum.
- R4: Decode reads the register file after the write-back of the same cycle. An instruction three slots after a producer sees the new value. Instructions one or two slots after it see the old value.
- R5: Register 0 always reads as zero, and writes aimed at it are dropped.
- R6: The all-zero word is a no-op, and so is any word that is not a valid add or store. These include an R-type word with another function code or with nonzero bits 10:6, and any other opcode. A no-op writes neither a register nor memory.
- R7: With `DEFECT`=1, the result of an instruction is written into the register named by the destination select of the word in decode during its write-back cycle. That word is the one three slots later in program order. When that word selects register 0, the result is lost.
- R8: The destination select takes bits 15:11 for any word whose bits 31:26 are 0 (add, all-zero word, other R-type words). It takes bits 20:16 for every other opcode, including store and undefined opcodes.
- R9: The register-write enable travels with its own instruction in both modes. A store reaching write-back writes no register, even when an add is in decode.
- R10: A negative store offset is sign-extended before it is added to the base register.
- R11: The instruction loading port and the register loading port take effect only while reset is asserted. They are ignored while the pipeline runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction memory write strobe (used only during reset) |
| prog_addr | input | log2(IMEM_DEPTH) | Instruction memory word index |
| prog_data | input | 32 | Instruction word to store |
| rf_load_we | input | 1 | Register preload strobe (used only during reset) |
| rf_load_idx | input | 5 | Register number to preload |
| rf_load_data | input | 32 | Preload value |
| rf_peek_idx | input | 5 | Register number to observe |
| rf_peek_data | output | 32 | Current contents of the observed register |
| dm_peek_addr | input | log2(DMEM_DEPTH) | Data memory word to observe |
| dm_peek_data | output | 32 | Current contents of the observed data word |

## Verification
The hardest situation to reach is the one in the defective routing where a result lands in a register chosen by an unrelated word three slots later. Programs are therefore laid out slot by slot, with all-zero words used as padding. An add is placed exactly three slots before a store, an add, an undefined-opcode word or a no-op, so that its result is diverted into bits 20:16, into bits 15:11, or into register 0. A store placed three slots before an add shows that the write enable is not taken from decode. A correct and a defective instance run the same program side by side. A bench model that replays the slot timing predicts every register and data word for each instance.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] FN_ADD    = 6'h20;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        K_NOP   = 2'd0,
        K_ADD   = 2'd1,
        K_STORE = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e kind;
        ridx_t rs;
        ridx_t rt;
        ridx_t dst;
        word_t imm;
    } dec_t;

    typedef struct packed {
        logic  reg_we;
        logic  mem_we;
        logic  use_imm;
        word_t a;
        word_t b;
        word_t imm;
        ridx_t dst;
    } idex_t;

    typedef struct packed {
        logic  reg_we;
        logic  mem_we;
        word_t res;
        word_t sdata;
        ridx_t dst;
    } exmem_t;

    typedef struct packed {
        logic  reg_we;
        word_t res;
        ridx_t dst;
    } memwb_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic ridx_t pick_dst(input logic sel_rd, input ridx_t rt, input ridx_t rd);
        return sel_rd ? rd : rt;
    endfunction

    function automatic kind_e classify(input word_t w);
        kind_e k;
        k = K_NOP;
        if (w[31:26] == OPC_RTYPE && w[5:0] == FN_ADD && w[10:6] == 5'd0)
            k = K_ADD;
        else if (w[31:26] == OPC_STORE)
            k = K_STORE;
        return k;
    endfunction

endpackage

// File: rtl/pipe5_fetch.sv
module pipe5_fetch
    import pipe5_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    localparam int IA_W = $clog2(IMEM_DEPTH),
    localparam int PC_W = IA_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic [IA_W-1:0] prog_addr,
    input  word_t           prog_data,
    output word_t           instr
);

    word_t           mem [IMEM_DEPTH];
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst && prog_we)
            mem[prog_addr] <= prog_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (pc_q < PC_W'(IMEM_DEPTH))
            pc_q <= pc_q + 1'b1;
    end

    always_comb begin
        if (pc_q < PC_W'(IMEM_DEPTH))
            instr = mem[pc_q[IA_W-1:0]];
        else
            instr = '0;
    end

    // R1: the first running cycle fetches from index 0
    p_pc_cleared_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_q == '0));

endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  word_t instr,
    output dec_t  dec
);

    logic sel_rd;

    always_comb begin
        sel_rd   = (instr[31:26] == OPC_RTYPE);
        dec.kind = classify(instr);
        dec.rs   = instr[25:21];
        dec.rt   = instr[20:16];
        dec.dst  = pick_dst(sel_rd, instr[20:16], instr[15:11]);
        dec.imm  = sext16(instr[15:0]);
    end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_we,
    input  ridx_t load_idx,
    input  word_t load_data,
    input  logic  wb_we,
    input  ridx_t wb_idx,
    input  word_t wb_data,
    input  ridx_t ra_idx,
    output word_t ra_data,
    input  ridx_t rb_idx,
    output word_t rb_data,
    input  ridx_t peek_idx,
    output word_t peek_data
);

    word_t regs [NREG];
    logic  wb_live;

    assign wb_live = !rst && wb_we && (wb_idx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_we && load_idx != '0)
                regs[load_idx] <= load_data;
        end else if (wb_live) begin
            regs[wb_idx] <= wb_data;
        end
    end

    function automatic word_t rd_port(input ridx_t idx);
        word_t v;
        if (idx == '0)
            v = '0;
        else if (wb_live && wb_idx == idx)
            v = wb_data;
        else
            v = regs[idx];
        return v;
    endfunction

    always_comb begin
        ra_data   = rd_port(ra_idx);
        rb_data   = rd_port(rb_idx);
        peek_data = (peek_idx == '0) ? '0 : regs[peek_idx];
    end

    // R5: register 0 reads zero on the decode port
    p_r0_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (ra_idx == '0) |-> (ra_data == '0));

endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem
    import pipe5_pkg::*;
#(
    parameter int DMEM_DEPTH = 64,
    localparam int DA_W = $clog2(DMEM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [DA_W-1:0] addr,
    input  word_t           wdata,
    input  logic [DA_W-1:0] peek_addr,
    output word_t           peek_data
);

    word_t mem [DMEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign peek_data = mem[peek_addr];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter bit DEFECT     = 1'b0,
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prog_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr,
    input  logic [31:0]                   prog_data,
    input  logic                          rf_load_we,
    input  logic [4:0]                    rf_load_idx,
    input  logic [31:0]                   rf_load_data,
    input  logic [4:0]                    rf_peek_idx,
    output logic [31:0]                   rf_peek_data,
    input  logic [$clog2(DMEM_DEPTH)-1:0] dm_peek_addr,
    output logic [31:0]                   dm_peek_data
);

    localparam int DA_W = $clog2(DMEM_DEPTH);

    word_t  if_instr;
    word_t  ifid_q;
    dec_t   id_dec;
    word_t  id_a, id_b;
    idex_t  idex_q;
    word_t  ex_sum;
    exmem_t exmem_q;
    memwb_t memwb_q;
    ridx_t  wb_dst;

    // fetch
    pipe5_fetch #(.IMEM_DEPTH(IMEM_DEPTH)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .instr     (if_instr)
    );

    always_ff @(posedge clk) begin
        if (rst) ifid_q <= '0;
        else     ifid_q <= if_instr;
    end

    // decode
    pipe5_decode u_decode (
        .instr (ifid_q),
        .dec   (id_dec)
    );

    pipe5_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .load_we   (rf_load_we),
        .load_idx  (rf_load_idx),
        .load_data (rf_load_data),
        .wb_we     (memwb_q.reg_we),
        .wb_idx    (wb_dst),
        .wb_data   (memwb_q.res),
        .ra_idx    (id_dec.rs),
        .ra_data   (id_a),
        .rb_idx    (id_dec.rt),
        .rb_data   (id_b),
        .peek_idx  (rf_peek_idx),
        .peek_data (rf_peek_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q <= '0;
        end else begin
            idex_q.reg_we  <= (id_dec.kind == K_ADD);
            idex_q.mem_we  <= (id_dec.kind == K_STORE);
            idex_q.use_imm <= (id_dec.kind == K_STORE);
            idex_q.a       <= id_a;
            idex_q.b       <= id_b;
            idex_q.imm     <= id_dec.imm;
            idex_q.dst     <= id_dec.dst;
        end
    end

    // execute
    assign ex_sum = idex_q.a + (idex_q.use_imm ? idex_q.imm : idex_q.b);

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q <= '0;
        end else begin
            exmem_q.reg_we <= idex_q.reg_we;
            exmem_q.mem_we <= idex_q.mem_we;
            exmem_q.res    <= ex_sum;
            exmem_q.sdata  <= idex_q.b;
            exmem_q.dst    <= idex_q.dst;
        end
    end

    // memory access
    pipe5_dmem #(.DMEM_DEPTH(DMEM_DEPTH)) u_dmem (
        .clk       (clk),
        .rst       (rst),
        .we        (exmem_q.mem_we),
        .addr      (exmem_q.res[DA_W-1:0]),
        .wdata     (exmem_q.sdata),
        .peek_addr (dm_peek_addr),
        .peek_data (dm_peek_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            memwb_q <= '0;
        end else begin
            memwb_q.reg_we <= exmem_q.reg_we;
            memwb_q.res    <= exmem_q.res;
            memwb_q.dst    <= exmem_q.dst;
        end
    end

    // write-back destination routing
    generate
        if (DEFECT) begin : g_live_dst
            assign wb_dst = id_dec.dst;
        end else begin : g_staged_dst
            logic [1:0] since_rst_q;

            assign wb_dst = memwb_q.dst;

            always_ff @(posedge clk) begin
                if (rst)                   since_rst_q <= '0;
                else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 1'b1;
            end

            // R2: destination reaches write-back two stages after execute holds it
            p_dst_carried_r2: assert property (@(posedge clk) disable iff (rst)
                (since_rst_q >= 2'd2) |-> (memwb_q.dst == $past(idex_q.dst, 2)));
        end
    endgenerate

    // R6: a zero word in decode issues no write of any kind
    p_nop_inert_r6: assert property (@(posedge clk) disable iff (rst)
        (ifid_q == '0) |=> (!idex_q.reg_we && !idex_q.mem_we));

    // R9: a store keeps its register-write enable low as it moves on
    p_store_no_rf_we_r9: assert property (@(posedge clk) disable iff (rst)
        idex_q.mem_we |=> (exmem_q.mem_we && !exmem_q.reg_we));

endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic        rf_load_we = 1'b0;
    logic [4:0]  rf_load_idx = '0;
    logic [31:0] rf_load_data = '0;
    logic [4:0]  rf_peek_idx = '0;
    logic [5:0]  dm_peek_addr = '0;
    logic [31:0] rf_peek_ok, rf_peek_bug, dm_peek_ok, dm_peek_bug;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] prog [16];
    int          plen;
    logic [31:0] init_rf [32];
    logic [31:0] exp_rf [2][32];
    logic [31:0] exp_dm [2][64];

    always #5 clk = ~clk;

    pipe5_core #(.DEFECT(1'b0)) dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .rf_load_we(rf_load_we), .rf_load_idx(rf_load_idx), .rf_load_data(rf_load_data),
        .rf_peek_idx(rf_peek_idx), .rf_peek_data(rf_peek_ok),
        .dm_peek_addr(dm_peek_addr), .dm_peek_data(dm_peek_ok)
    );

    pipe5_core #(.DEFECT(1'b1)) dut_bug (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .rf_load_we(rf_load_we), .rf_load_idx(rf_load_idx), .rf_load_data(rf_load_data),
        .rf_peek_idx(rf_peek_idx), .rf_peek_data(rf_peek_bug),
        .dm_peek_addr(dm_peek_addr), .dm_peek_data(dm_peek_bug)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] op_add(int rd, int rs, int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, 6'h20};
    endfunction

    function automatic logic [31:0] op_sw(int rt, int off, int rs);
        return {6'h2B, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Slot-timing model: word j reads in its decode cycle, which is also the
    // write-back cycle of word j-3; mode 1 routes that write by word j.
    task automatic model(int m);
        logic [31:0] rf [32];
        logic [31:0] res [16];
        bit          we [16];
        logic [4:0]  dsto [16];
        logic [31:0] w, a, b, addr;
        logic [4:0]  d;
        for (int r = 0; r < 32; r++) rf[r] = (r == 0) ? 32'h0 : init_rf[r];
        for (int i = 0; i < 64; i++) exp_dm[m][i] = 32'h0;
        for (int j = 0; j < plen + 4; j++) begin
            w = (j < plen) ? prog[j] : 32'h0;
            if (j >= 3 && we[j-3]) begin
                if (m == 1) d = (w[31:26] == 6'h00) ? w[15:11] : w[20:16];
                else        d = dsto[j-3];
                if (d != 5'd0) rf[d] = res[j-3];
            end
            if (j < plen) begin
                a = rf[w[25:21]];
                b = rf[w[20:16]];
                we[j] = 1'b0;
                dsto[j] = 5'd0;
                res[j] = 32'h0;
                if (w[31:26] == 6'h00 && w[5:0] == 6'h20 && w[10:6] == 5'd0) begin
                    we[j] = 1'b1;
                    res[j] = a + b;
                    dsto[j] = w[15:11];
                end else if (w[31:26] == 6'h2B) begin
                    addr = a + {{16{w[15]}}, w[15:0]};
                    exp_dm[m][addr[5:0]] = b;
                end
            end
        end
        for (int r = 0; r < 32; r++) exp_rf[m][r] = rf[r];
    endtask

    task automatic do_setup();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            prog_we = 1'b1; prog_addr = 6'(i);
            prog_data = (i < plen) ? prog[i] : 32'h0;
            @(negedge clk);
        end
        prog_we = 1'b0;
        for (int r = 0; r < 32; r++) begin
            rf_load_we = 1'b1; rf_load_idx = 5'(r); rf_load_data = init_rf[r];
            @(negedge clk);
        end
        rf_load_we = 1'b0;
    endtask

    task automatic do_run(int n);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(string req_ok, string req_bug);
        model(0);
        model(1);
        for (int r = 0; r < 32; r++) begin
            rf_peek_idx = 5'(r); #1;
            chk(req_ok,  $sformatf("dut r%0d", r),     rf_peek_ok,  exp_rf[0][r]);
            chk(req_bug, $sformatf("dut_bug r%0d", r), rf_peek_bug, exp_rf[1][r]);
        end
        for (int i = 0; i < 64; i++) begin
            dm_peek_addr = 6'(i); #1;
            chk(req_ok,  $sformatf("dut mem[%0d]", i),     dm_peek_ok,  exp_dm[0][i]);
            chk(req_bug, $sformatf("dut_bug mem[%0d]", i), dm_peek_bug, exp_dm[1][i]);
        end
    endtask

    task automatic run_prog(int n, string req_ok, string req_bug);
        plen = n;
        do_setup();
        do_run(n + 12);
        check_all(req_ok, req_bug);
    endtask

    // R2: independent adds in correct mode; the defective copy misroutes (R7)
    task automatic t_add_basic();
        prog[0] = op_add(13, 9, 10);
        prog[1] = op_add(14, 11, 12);
        prog[2] = op_add(15, 10, 10);
        run_prog(3, "R2", "R7");
    endtask

    // R4: a producer seen at distance 3, stale at distances 1 and 2
    task automatic t_read_timing();
        prog[0] = op_add(13, 9, 10);
        prog[1] = op_add(14, 13, 9);
        prog[2] = op_add(15, 13, 9);
        prog[3] = op_add(16, 13, 9);
        run_prog(4, "R4", "R7");
    endtask

    // R3: stores with positive and wrapping offsets
    task automatic t_store();
        prog[0] = op_sw(10, 0, 12);
        prog[1] = op_sw(11, 3, 12);
        prog[2] = op_sw(9, 16'h40, 12);
        run_prog(3, "R3", "R3");
    endtask

    // R10: negative offsets are sign-extended
    task automatic t_neg_offset();
        prog[0] = op_sw(10, -3, 12);
        prog[1] = op_sw(11, -1, 12);
        prog[2] = op_sw(9, -8, 12);
        run_prog(3, "R10", "R10");
    endtask

    // R1: reset clears data memory and leaves preloaded registers intact
    task automatic t_reset();
        plen = 0;
        do_setup();
        for (int i = 0; i < 64; i++) begin
            dm_peek_addr = 6'(i); #1;
            chk("R1", $sformatf("dut mem[%0d] in reset", i),     dm_peek_ok,  32'h0);
            chk("R1", $sformatf("dut_bug mem[%0d] in reset", i), dm_peek_bug, 32'h0);
        end
        for (int r = 9; r <= 12; r++) begin
            rf_peek_idx = 5'(r); #1;
            chk("R1", $sformatf("dut r%0d in reset", r), rf_peek_ok, init_rf[r]);
        end
        do_run(10);
        check_all("R1", "R1");
    endtask

    // R5: writes to register 0 dropped, reads of it return zero
    task automatic t_reg_zero();
        prog[0] = op_add(0, 9, 10);
        prog[1] = 32'h0;
        prog[2] = 32'h0;
        prog[3] = op_add(20, 0, 9);
        run_prog(4, "R5", "R5");
        rf_peek_idx = 5'd0; #1;
        chk("R5", "dut r0", rf_peek_ok, 32'h0);
    endtask

    // R6 / R8: no-op words; an undefined opcode still selects bits 20:16
    task automatic t_nop_words();
        prog[0] = op_add(19, 9, 9);
        prog[1] = 32'h0;
        prog[2] = {6'h00, 5'd9, 5'd10, 5'd17, 5'd0, 6'h22};
        prog[3] = {6'h23, 5'd12, 5'd18, 16'h0001};
        prog[4] = {6'h00, 5'd9, 5'd10, 5'd21, 5'd3, 6'h20};
        run_prog(5, "R6", "R8");
    endtask

    // R7 / R8: add three slots before an add (bits 15:11) and a store (bits 20:16)
    task automatic t_defect_route();
        prog[0] = op_add(9, 10, 11);
        prog[1] = op_sw(10, 0, 12);
        prog[2] = op_sw(10, 1, 12);
        prog[3] = op_add(10, 11, 12);
        prog[4] = op_sw(11, 2, 12);
        prog[5] = op_sw(11, 3, 12);
        prog[6] = op_sw(11, 4, 12);
        run_prog(7, "R2", "R7");
    endtask

    // R9: a store in write-back writes no register while an add decodes
    task automatic t_store_then_add();
        prog[0] = op_sw(9, 0, 12);
        prog[1] = 32'h0;
        prog[2] = 32'h0;
        prog[3] = op_add(13, 9, 10);
        run_prog(4, "R2", "R9");
    endtask

    // R11: loading ports ignored while running
    task automatic t_load_gated();
        plen = 0;
        do_setup();
        rst = 1'b0;
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 6'd3; prog_data = op_add(20, 9, 10);
        rf_load_we = 1'b1; rf_load_idx = 5'd21; rf_load_data = 32'hDEAD_0000;
        @(negedge clk);
        prog_we = 1'b0; rf_load_we = 1'b0;
        repeat (15) @(negedge clk);
        rf_peek_idx = 5'd20; #1;
        chk("R11", "dut r20", rf_peek_ok,  init_rf[20]);
        chk("R11", "dut_bug r20", rf_peek_bug, init_rf[20]);
        rf_peek_idx = 5'd21; #1;
        chk("R11", "dut r21", rf_peek_ok,  init_rf[21]);
        chk("R11", "dut_bug r21", rf_peek_bug, init_rf[21]);
    endtask

    initial begin
        for (int r = 0; r < 32; r++) init_rf[r] = (r == 0) ? 32'h0 : (32'h5000 + 32'(r));
        init_rf[9]  = 32'h0000_0100;
        init_rf[10] = 32'h0000_0200;
        init_rf[11] = 32'h0000_0300;
        init_rf[12] = 32'h0000_0008;
        for (int i = 0; i < 16; i++) prog[i] = 32'h0;

        t_add_basic();
        t_read_timing();
        t_store();
        t_reset();
        t_neg_offset();
        t_reg_zero();
        t_nop_words();
        t_defect_route();
        t_store_then_add();
        t_load_gated();

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule